// File: doc/BRIEF.md
# SDRAM Burst Write Command Sequencer

This block carries out one 32-byte write burst into a synchronous DRAM on a 64-bit data bus. A requester offers a bank, a row, a starting column and four 64-bit data words. The block then opens the row with an activate command. After a configurable RAS-to-CAS gap it issues a single write-with-auto-precharge command, and it drives the four data beats in consecutive cycles. The first beat goes out together with the write command. The column order wraps inside the 32-byte aligned block, starting at the requested column. A DMA acknowledge strobe runs two cycles ahead of the data.

Because the bank precharges on its own after the write, the block issues no further command for a while once the last beat is out. It waits a programmable write-recovery interval (a 3-bit count) and then a programmable precharge interval. Only after both does it drop busy and take the next request.

The request side is a valid/ready handshake. `req_ready` is the inverse of `busy`. A requester that finds `req_ready` low must hold `req_valid` and its fields steady until a clock edge at which both are high. The block never buffers a second request. Configuration inputs are plain pins, sampled at the acceptance edge.

Top module: `sdwr_burst_seq`

## Requirements
- R1: After reset the block is idle: busy is 0, req_ready is 1, sd_cmd is NOP (4'b0111, bit order cs_n,ras_n,cas_n,we_n), dma_ack is 0, sd_dq_oe is 0 and sd_dqm is all ones.
- R2: A request is accepted at a clock edge where req_valid and req_ready are both 1. busy is 1 from the cycle after acceptance until the last precharge-wait cycle, and req_ready equals not busy. A request held while busy is taken at the first edge at which busy is 0.
- R3: The cycle right after acceptance carries ACTIVATE (4'b0011), with the bank on sd_ba and the row on sd_addr.
- R4: Exactly N NOP cycles separate ACTIVATE from WRITE (4'b0100), where N is cfg_rcd, and a cfg_rcd of 0 is treated as 1.
- R5: During WRITE, sd_ba carries the bank and sd_addr carries the starting column in its low bits with the auto-precharge bit (bit 10) set.
- R6: Four data beats occur in consecutive cycles, the first in the WRITE cycle. sd_dq_oe is 1 exactly in those four cycles. sd_dqm is all zeros during the beats and all ones otherwise.
- R7: Beat k carries data word (c+k) mod 4, where c is the low two bits of the column and word i is req_data[64*i+63:64*i].
- R8: dma_ack is 1 for exactly four cycles, starting two cycles before the first data beat.
- R9: After the last beat there are cfg_twr NOP cycles (0 to 7), then cfg_tpc NOP cycles (0 to 7), and busy falls after them. A burst therefore keeps busy high for 5+N+cfg_twr+cfg_tpc cycles.
- R10: The cfg inputs are sampled at acceptance. Changing them during a burst does not alter that burst's timing.
- R11: Each burst issues exactly one ACTIVATE and one WRITE. Every other cycle carries NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (not busy) |
| req_bank | input | 2 | Bank of the burst |
| req_row | input | 13 | Row address |
| req_col | input | 10 | Starting column, in 64-bit words |
| req_data | input | 256 | Four 64-bit words, word 0 in the low bits |
| cfg_rcd | input | 3 | RAS-to-CAS gap in cycles, 0 acts as 1 |
| cfg_twr | input | 3 | Write-recovery cycles |
| cfg_tpc | input | 3 | Precharge-wait cycles |
| busy | output | 1 | Burst in progress, including hold-off |
| sd_cmd | output | 4 | {cs_n,ras_n,cas_n,we_n} |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | 13 | SDRAM address lines |
| sd_dq | output | 64 | Write data |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dqm | output | 8 | Byte masks, 1 masks a byte |
| dma_ack | output | 1 | DMA acknowledge strobe |

## Verification
The bench walks every cycle of each burst against a timeline computed from the configuration. It targets the shortest gap (cfg_rcd of 1, and 0 standing for 1), where an acknowledge tied to the gap state instead of the activate cycle would start one cycle late. It sets the write-recovery and precharge counts to zero and to seven. A design that skipped a zero count badly would stall a cycle or end one cycle early. Starting columns at all four offsets expose a wrap done modulo something other than four. Changing the configuration mid-burst, and holding a second request during busy, catch a design that reads live configuration or accepts a request early or a cycle late.

// File: rtl/sdwr_pkg.sv
package sdwr_pkg;

  localparam int CFG_W = 3;

  typedef enum logic [3:0] {
    CMD_ACT   = 4'b0011,
    CMD_WRITE = 4'b0100,
    CMD_NOP   = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCD,
    ST_DATA,
    ST_WREC,
    ST_PCHG
  } seq_state_e;

endpackage

// File: rtl/sdwr_ctrl.sv
module sdwr_ctrl
  import sdwr_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int LEAD  = 2,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [CFG_W-1:0]  cfg_rcd,
  input  logic [CFG_W-1:0]  cfg_twr,
  input  logic [CFG_W-1:0]  cfg_tpc,
  output seq_state_e        state,
  output logic [BEAT_W-1:0] beat,
  output logic              dma_ack
);

  logic [CFG_W-1:0] cnt;
  logic [CFG_W-1:0] rcd_q, twr_q, tpc_q;
  logic [CFG_W-1:0] rcd_eff;

  assign rcd_eff = (cfg_rcd == '0) ? CFG_W'(1) : cfg_rcd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      beat  <= '0;
      rcd_q <= CFG_W'(1);
      twr_q <= '0;
      tpc_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_fire) begin
            state <= ST_ACT;
            rcd_q <= rcd_eff;
            twr_q <= cfg_twr;
            tpc_q <= cfg_tpc;
          end
        end
        ST_ACT: begin
          cnt   <= rcd_q;
          state <= ST_RCD;
        end
        ST_RCD: begin
          if (cnt == CFG_W'(1)) begin
            state <= ST_DATA;
            beat  <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_DATA: begin
          beat <= beat + 1'b1;
          if (beat == BEAT_W'(BEATS - 1)) begin
            if (twr_q != '0) begin
              state <= ST_WREC;
              cnt   <= twr_q;
            end else if (tpc_q != '0) begin
              state <= ST_PCHG;
              cnt   <= tpc_q;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_WREC: begin
          if (cnt == CFG_W'(1)) begin
            if (tpc_q != '0) begin
              state <= ST_PCHG;
              cnt   <= tpc_q;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PCHG: begin
          if (cnt == CFG_W'(1)) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Strobe leads the data by LEAD cycles and lasts BEATS cycles.
  always_comb begin
    dma_ack = 1'b0;
    case (state)
      ST_ACT:  dma_ack = (rcd_q == CFG_W'(1));
      ST_RCD:  dma_ack = (cnt <= CFG_W'(LEAD));
      ST_DATA: dma_ack = (beat < BEAT_W'(BEATS - LEAD));
      default: dma_ack = 1'b0;
    endcase
  end

  AST_GAP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RCD |-> cnt != '0); // R4

endmodule

// File: rtl/sdwr_dpath.sv
module sdwr_dpath
  import sdwr_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int DQ_W   = 64,
  parameter int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int MASK_W = DQ_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_fire,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [ROW_W-1:0]      req_row,
  input  logic [COL_W-1:0]      req_col,
  input  logic [BEATS*DQ_W-1:0] req_data,
  input  seq_state_e            state,
  input  logic [BEAT_W-1:0]     beat,
  output logic [3:0]            sd_cmd,
  output logic [BANK_W-1:0]     sd_ba,
  output logic [ADDR_W-1:0]     sd_addr,
  output logic [DQ_W-1:0]       sd_dq,
  output logic                  sd_dq_oe,
  output logic [MASK_W-1:0]     sd_dqm
);

  logic [BANK_W-1:0]     bank_q;
  logic [ROW_W-1:0]      row_q;
  logic [COL_W-1:0]      col_q;
  logic [BEATS*DQ_W-1:0] data_q;
  logic [DQ_W-1:0]       word [BEATS];
  logic [BEAT_W-1:0]     sel;
  logic                  first_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      data_q <= '0;
    end else if (req_fire) begin
      bank_q <= req_bank;
      row_q  <= req_row;
      col_q  <= req_col;
      data_q <= req_data;
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    assign word[g] = data_q[g*DQ_W +: DQ_W];
  end

  // Wrap within the aligned block: offset arithmetic truncated to BEAT_W.
  assign sel        = col_q[BEAT_W-1:0] + beat;
  assign first_beat = (state == ST_DATA) && (beat == '0);

  always_comb begin
    sd_cmd  = CMD_NOP;
    sd_addr = '0;
    if (state == ST_ACT) begin
      sd_cmd              = CMD_ACT;
      sd_addr[ROW_W-1:0]  = row_q;
    end else if (first_beat) begin
      sd_cmd              = CMD_WRITE;
      sd_addr[COL_W-1:0]  = col_q;
      sd_addr[AP_BIT]     = 1'b1;
    end
  end

  assign sd_ba    = bank_q;
  assign sd_dq_oe = (state == ST_DATA);
  assign sd_dq    = sd_dq_oe ? word[sel] : '0;
  assign sd_dqm   = sd_dq_oe ? '0 : '1;

  AST_MASK_CLOSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> sd_dqm == '1 && !sd_dq_oe); // R6

endmodule

// File: rtl/sdwr_burst_seq.sv
module sdwr_burst_seq
  import sdwr_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int DQ_W   = 64,
  parameter int LEAD   = 2,
  localparam int BEATS  = 256 / DQ_W,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int MASK_W = DQ_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [ROW_W-1:0]      req_row,
  input  logic [COL_W-1:0]      req_col,
  input  logic [BEATS*DQ_W-1:0] req_data,
  input  logic [CFG_W-1:0]      cfg_rcd,
  input  logic [CFG_W-1:0]      cfg_twr,
  input  logic [CFG_W-1:0]      cfg_tpc,
  output logic                  busy,
  output logic [3:0]            sd_cmd,
  output logic [BANK_W-1:0]     sd_ba,
  output logic [ADDR_W-1:0]     sd_addr,
  output logic [DQ_W-1:0]       sd_dq,
  output logic                  sd_dq_oe,
  output logic [MASK_W-1:0]     sd_dqm,
  output logic                  dma_ack
);

  seq_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic              req_fire;

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;

  sdwr_ctrl #(
    .BEATS (BEATS),
    .LEAD  (LEAD)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .cfg_rcd  (cfg_rcd),
    .cfg_twr  (cfg_twr),
    .cfg_tpc  (cfg_tpc),
    .state    (state),
    .beat     (beat),
    .dma_ack  (dma_ack)
  );

  sdwr_dpath #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT),
    .DQ_W   (DQ_W),
    .BEATS  (BEATS)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .req_bank (req_bank),
    .req_row  (req_row),
    .req_col  (req_col),
    .req_data (req_data),
    .state    (state),
    .beat     (beat),
    .sd_cmd   (sd_cmd),
    .sd_ba    (sd_ba),
    .sd_addr  (sd_addr),
    .sd_dq    (sd_dq),
    .sd_dq_oe (sd_dq_oe),
    .sd_dqm   (sd_dqm)
  );

  AST_ACT_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cmd == CMD_ACT |=> sd_cmd == CMD_NOP); // R4
  AST_WRITE_CARRIES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cmd == CMD_WRITE |-> sd_dq_oe && sd_addr[AP_BIT]); // R5
  AST_ACK_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_dq_oe) |-> $past(dma_ack, 2) && !$past(dma_ack, 3)); // R8
  AST_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_dq_oe) |-> $past(sd_dq_oe, 4) && !$past(sd_dq_oe, 5)); // R6
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sd_cmd == CMD_NOP && !dma_ack); // R2
  AST_ACT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> sd_cmd == CMD_ACT && busy); // R3

endmodule

// File: tb/tb_sdwr_burst_seq.sv
module tb_sdwr_burst_seq;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_bank = '0;
  logic [12:0]  req_row = '0;
  logic [9:0]   req_col = '0;
  logic [255:0] req_data = '0;
  logic [2:0]   cfg_rcd = 3'd1, cfg_twr = '0, cfg_tpc = '0;
  logic         busy;
  logic [3:0]   sd_cmd;
  logic [1:0]   sd_ba;
  logic [12:0]  sd_addr;
  logic [63:0]  sd_dq;
  logic         sd_dq_oe;
  logic [7:0]   sd_dqm;
  logic         dma_ack;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sdwr_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_data(req_data),
    .cfg_rcd(cfg_rcd), .cfg_twr(cfg_twr), .cfg_tpc(cfg_tpc), .busy(busy),
    .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq(sd_dq),
    .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm), .dma_ack(dma_ack)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at %0t: actual=%0h expected=%0h", rq, what, $time, act, exp);
    end
  endtask

  function automatic logic [63:0] word_of(input logic [255:0] d, input int w);
    return d[64*w +: 64];
  endfunction

  // One burst, checked every cycle against a timeline built from the requirements.
  task automatic burst(input logic [1:0] bank, input logic [12:0] row, input logic [9:0] col,
                       input logic [255:0] data, input int rcd, input int twr, input int tpc,
                       input bit pre, input bit keep, input bit chg_cfg);
    int n = (rcd == 0) ? 1 : rcd;
    int wr = 2 + n;
    int last = 5 + n + twr + tpc;
    if (!pre) @(negedge clk);
    req_bank = bank; req_row = row; req_col = col; req_data = data;
    cfg_rcd = 3'(rcd); cfg_twr = 3'(twr); cfg_tpc = 3'(tpc);
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2", "ready before accept", 256'(req_ready), 256'(1));
    for (int i = 1; i <= last + 1; i++) begin
      @(negedge clk);
      if (i == 1) begin
        if (!keep) req_valid = 1'b0;
        if (chg_cfg) begin
          cfg_rcd = 3'(rcd ^ 5); cfg_twr = 3'(twr ^ 6); cfg_tpc = 3'(tpc ^ 3);
        end
      end
      if (i == 1) begin
        chk(sd_cmd == 4'b0011, "R3", "activate", 256'(sd_cmd), 256'(4'b0011));
        chk(sd_addr == row && sd_ba == bank, "R3", "row/bank", 256'({sd_ba, sd_addr}), 256'({bank, row}));
        if (keep) chk(req_ready == 1'b0, "R2", "ready while busy", 256'(req_ready), 256'(0));
      end else if (i == wr) begin
        chk(sd_cmd == 4'b0100, "R4", "write cmd", 256'(sd_cmd), 256'(4'b0100));
        chk(sd_addr == (13'h400 | 13'(col)) && sd_ba == bank, "R5", "col/ap/bank",
            256'({sd_ba, sd_addr}), 256'({bank, 13'h400 | 13'(col)}));
      end else begin
        chk(sd_cmd == 4'b0111, "R11", "nop", 256'(sd_cmd), 256'(4'b0111));
      end
      begin
        bit beat_on = (i >= wr) && (i <= wr + 3);
        bit ack_on  = (i >= n) && (i <= n + 3);
        bit busy_on = (i <= last);
        chk(sd_dq_oe == beat_on, "R6", "dq_oe", 256'(sd_dq_oe), 256'(beat_on));
        chk(sd_dqm == (beat_on ? 8'h00 : 8'hff), "R6", "dqm", 256'(sd_dqm), 256'(beat_on ? 8'h00 : 8'hff));
        if (beat_on) begin
          logic [63:0] e = word_of(data, (int'(col[1:0]) + i - wr) % 4);
          chk(sd_dq == e, "R7", "beat data", 256'(sd_dq), 256'(e));
        end
        chk(dma_ack == ack_on, "R8", "dma_ack", 256'(dma_ack), 256'(ack_on));
        chk(busy == busy_on, chg_cfg ? "R10" : "R9", "busy", 256'(busy), 256'(busy_on));
        chk(req_ready == !busy_on, "R2", "ready", 256'(req_ready), 256'(!busy_on));
      end
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0 && req_ready == 1'b1, "R1", "busy/ready", 256'({busy, req_ready}), 256'(2'b01));
    chk(sd_cmd == 4'b0111, "R1", "cmd", 256'(sd_cmd), 256'(4'b0111));
    chk(!dma_ack && !sd_dq_oe, "R1", "ack/oe", 256'({dma_ack, sd_dq_oe}), 256'(0));
    chk(sd_dqm == 8'hff, "R1", "dqm", 256'(sd_dqm), 256'(8'hff));
  endtask

  function automatic logic [255:0] pat(input logic [7:0] s);
    return {8'h30 + s, 56'h0,  8'h20 + s, 56'h1,  8'h10 + s, 56'h2,  s, 56'h3};
  endfunction

  task automatic t_basic();   burst(2'd1, 13'h1abc, 10'h040, pat(8'h01), 2, 2, 3, 0, 0, 0); endtask
  task automatic t_wrap3();   burst(2'd2, 13'h0123, 10'h1f3, pat(8'h05), 1, 0, 1, 0, 0, 0); endtask
  task automatic t_long();    burst(2'd3, 13'h1fff, 10'h002, pat(8'h09), 7, 7, 7, 0, 0, 0); endtask
  task automatic t_rcd_zero(); burst(2'd0, 13'h0001, 10'h3f1, pat(8'h0d), 0, 0, 0, 0, 0, 0); endtask
  task automatic t_cfg_change(); burst(2'd1, 13'h0a0a, 10'h155, pat(8'h41), 3, 1, 2, 0, 0, 1); endtask
  task automatic t_back2back();
    burst(2'd2, 13'h0777, 10'h006, pat(8'h51), 2, 1, 1, 0, 1, 0);
    burst(2'd3, 13'h0888, 10'h009, pat(8'h61), 1, 3, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap3();
    t_long();
    t_rcd_zero();
    t_cfg_change();
    t_back2back();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule